// File: doc/BRIEF.md
# USB Device Connect and Suspend Status Controller

This block keeps the connection and power-state status of a full-speed USB device. It owns the connect flag, which drives an active-low soft-connect output that enables the bus pull-up. It watches a bus-power sense input and drops the connection when that input stays low for longer than three milliseconds. It also watches an upstream bus-activity input, marks the device as suspended after three milliseconds of silence, and issues a remote wake-up request when software asks for one.

Software reaches the block through a byte-wide command/data port. A command byte selects the target. Data writes and data reads that follow then act on that target until the next command byte arrives. The status target accepts one written byte and returns the status byte on a read. Reading the status clears its two change flags. A separate test target returns a fixed 16-bit pattern. Either change flag raises a single status interrupt. The parameter `CYCLES_PER_MS` scales both millisecond windows.

Top module: `usb_devstat_ctrl`

## Requirements
- R1: Status bit 0 is the connect flag. A status write loads it from data bit 0, and `connectN` is the inverse of the flag: low while connected, high while disconnected.
- R2: The connect flag is cleared by hardware only after `vbusSense` has been sampled low on 3*CYCLES_PER_MS+1 consecutive clock edges. A low run one edge shorter leaves the connection intact.
- R3: Status bit 1, the connect-change flag, is set when the bus-power loss drops the connection. It is cleared by a status read, unless it is set again in the same cycle.
- R4: While connected, status bit 2, the suspend flag, is set after `busActivity` has been sampled low on 3*CYCLES_PER_MS+1 consecutive edges. A shorter idle run has no effect, and the flag is never set while disconnected.
- R5: The suspend flag clears on the first edge at which `busActivity` is high, and it also clears when the connection drops.
- R6: A status write with data bit 2 at 0, made while suspended and connected, raises `remoteWakeup` for exactly one cycle after that write. The same write in any other state, or with data bit 2 at 1, produces no pulse and does not change the suspend flag.
- R7: Status bit 3, the suspend-change flag, is set on every change of the suspend flag, whether from entering suspend, from resume activity or from disconnection. It is cleared by a status read.
- R8: `devStatIrq` is high exactly while at least one of the two change flags is set.
- R9: Command 0xFE selects the status register. A data read returns {4'b0, suspend-change, suspend, connect-change, connect} on `dataRdByte` one cycle after the read strobe. Writes to bits 1, 3 and 7..4 have no effect.
- R10: Command 0xFD selects the test register. Successive reads return 0x0F and then 0xA5, alternating, starting with 0x0F after each command byte.
- R11: A read made after any other command byte returns 0x00, and a write made after any other command byte changes nothing.
- R12: After reset all status bits are 0, `connectN` is high, and `remoteWakeup` and `devStatIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdCode | input | 8 | Command byte |
| dataWrValid | input | 1 | Data write strobe |
| dataWrByte | input | 8 | Data write byte |
| dataRdReq | input | 1 | Data read strobe |
| dataRdByte | output | 8 | Read data, valid the cycle after the strobe |
| vbusSense | input | 1 | Bus-power present, synchronous to clk |
| busActivity | input | 1 | Upstream bus activity seen this cycle |
| connectN | output | 1 | Soft-connect output, low enables pull-up |
| remoteWakeup | output | 1 | One-cycle remote wake-up request |
| devStatIrq | output | 1 | Device-status interrupt |

## Verification
The properties assume that `vbusSense` and `busActivity` are already synchronous to `clk`. They also assume that at most one of the command, write and read strobes is active in a given cycle, because the block gives a command byte priority over data that arrives in the same cycle. The stimulus changes every input on the falling edge, asserts exactly one strobe per access, and always sends a command byte before the data accesses that depend on it. The bench raises `vbusSense` again before it reconnects, so that a connect write is not immediately undone by a bus-power timeout that is still expired.

// File: rtl/devstat_pkg.sv
package devstat_pkg;

  localparam logic [7:0] CMD_STATUS = 8'hFE;
  localparam logic [7:0] CMD_TEST   = 8'hFD;
  localparam logic [15:0] TEST_WORD = 16'hA50F;

  typedef struct packed {
    logic wrStat;
    logic rdStat;
    logic rdTestLo;
    logic rdTestHi;
    logic rdOther;
  } devStrobes_t;

endpackage

// File: rtl/devstat_mstimer.sv
module devstat_mstimer #(
  parameter int LIMIT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic cond,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] runLen;

  // Saturating run counter, restarts whenever the condition drops.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (!cond) begin
      runLen <= '0;
    end else if (runLen != LIM) begin
      runLen <= runLen + 1'b1;
    end
  end

  assign expired = cond && (runLen == LIM);
endmodule

// File: rtl/devstat_ctrl.sv
module devstat_ctrl
  import devstat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdCode,
  input  logic        dataWrValid,
  input  logic        dataRdReq,
  output devStrobes_t stb
);
  logic [7:0] curCmd;
  logic       testHalf;
  logic       isStatus;
  logic       isTest;
  logic       rdGo;
  logic       wrGo;

  assign isStatus = (curCmd == CMD_STATUS);
  assign isTest   = (curCmd == CMD_TEST);
  // a command byte takes precedence over data in the same cycle
  assign rdGo     = dataRdReq && !cmdValid;
  assign wrGo     = dataWrValid && !cmdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCmd   <= 8'h00;
      testHalf <= 1'b0;
    end else if (cmdValid) begin
      curCmd   <= cmdCode;
      testHalf <= 1'b0;
    end else if (rdGo && isTest) begin
      testHalf <= ~testHalf;
    end
  end

  always_comb begin
    stb          = '0;
    stb.wrStat   = wrGo && isStatus;
    stb.rdStat   = rdGo && isStatus;
    stb.rdTestLo = rdGo && isTest && !testHalf;
    stb.rdTestHi = rdGo && isTest && testHalf;
    stb.rdOther  = rdGo && !isStatus && !isTest;
  end
endmodule

// File: rtl/devstat_dp.sv
module devstat_dp
  import devstat_pkg::*;
#(
  parameter int CYCLES_PER_MS = 48000
) (
  input  logic        clk,
  input  logic        rstN,
  input  devStrobes_t stb,
  input  logic [7:0]  dataWrByte,
  input  logic        vbusSense,
  input  logic        busActivity,
  output logic [7:0]  dataRdByte,
  output logic        connectN,
  output logic        remoteWakeup,
  output logic        devStatIrq
);
  localparam int WINDOW = 3 * CYCLES_PER_MS;

  logic con, conCh, sus, susCh;
  logic conNx, conChNx, susNx, susChNx;
  logic vbusGone, idleLong;
  logic wakeNx;
  logic [7:0] statusByte;

  devstat_mstimer #(.LIMIT(WINDOW)) vbusTimer (
    .clk(clk), .rstN(rstN), .cond(!vbusSense), .expired(vbusGone)
  );

  devstat_mstimer #(.LIMIT(WINDOW)) idleTimer (
    .clk(clk), .rstN(rstN), .cond(con && !busActivity), .expired(idleLong)
  );

  assign statusByte = {4'b0000, susCh, sus, conCh, con};

  always_comb begin
    conNx   = con;
    conChNx = conCh & ~stb.rdStat;
    susNx   = sus;
    susChNx = susCh & ~stb.rdStat;
    if (stb.wrStat) conNx = dataWrByte[0];
    // bus-power loss overrides any software connect in the same cycle
    if (vbusGone && con) begin
      conNx   = 1'b0;
      conChNx = 1'b1;
    end
    if (sus && (!conNx || busActivity)) begin
      susNx   = 1'b0;
      susChNx = 1'b1;
    end else if (!sus && idleLong && con && conNx) begin
      susNx   = 1'b1;
      susChNx = 1'b1;
    end
  end

  assign wakeNx = stb.wrStat && !dataWrByte[2] && sus && con;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      con          <= 1'b0;
      conCh        <= 1'b0;
      sus          <= 1'b0;
      susCh        <= 1'b0;
      remoteWakeup <= 1'b0;
      dataRdByte   <= 8'h00;
    end else begin
      con          <= conNx;
      conCh        <= conChNx;
      sus          <= susNx;
      susCh        <= susChNx;
      remoteWakeup <= wakeNx;
      if (stb.rdStat)        dataRdByte <= statusByte;
      else if (stb.rdTestLo) dataRdByte <= TEST_WORD[7:0];
      else if (stb.rdTestHi) dataRdByte <= TEST_WORD[15:8];
      else if (stb.rdOther)  dataRdByte <= 8'h00;
    end
  end

  assign connectN   = ~con;
  assign devStatIrq = conCh | susCh;
endmodule

// File: rtl/usb_devstat_ctrl.sv
module usb_devstat_ctrl
  import devstat_pkg::*;
#(
  parameter int CYCLES_PER_MS = 48000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       dataWrValid,
  input  logic [7:0] dataWrByte,
  input  logic       dataRdReq,
  output logic [7:0] dataRdByte,
  input  logic       vbusSense,
  input  logic       busActivity,
  output logic       connectN,
  output logic       remoteWakeup,
  output logic       devStatIrq
);
  devStrobes_t stb;

  devstat_ctrl ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .dataWrValid(dataWrValid), .dataRdReq(dataRdReq), .stb(stb)
  );

  devstat_dp #(.CYCLES_PER_MS(CYCLES_PER_MS)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataWrByte(dataWrByte),
    .vbusSense(vbusSense), .busActivity(busActivity),
    .dataRdByte(dataRdByte), .connectN(connectN),
    .remoteWakeup(remoteWakeup), .devStatIrq(devStatIrq)
  );
endmodule

// File: rtl/devstat_chk.sv
module devstat_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [7:0] cmdCode,
  input logic       dataWrValid,
  input logic [7:0] dataWrByte,
  input logic       dataRdReq,
  input logic [7:0] dataRdByte,
  input logic       vbusSense,
  input logic       busActivity,
  input logic       connectN,
  input logic       remoteWakeup,
  input logic       devStatIrq
);
  // R1
  connect_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(connectN) |-> $past(dataWrValid));

  // R2
  drop_needs_vbus_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(connectN) && !$past(dataWrValid)) |-> $past(!vbusSense));

  // R3
  drop_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(connectN) && !$past(dataWrValid)) |-> devStatIrq);

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    remoteWakeup |=> !remoteWakeup);

  // R6
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    remoteWakeup |-> ($past(dataWrValid) && !$past(dataWrByte[2]) && !$past(connectN)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (connectN && !devStatIrq && !remoteWakeup));
endmodule

bind usb_devstat_ctrl devstat_chk chk (.*);

// File: tb/tb_usb_devstat_ctrl.sv
module tb_usb_devstat_ctrl;
  localparam int CPM = 4;
  localparam int WIN = 3 * CPM;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, dataWrValid = 1'b0, dataRdReq = 1'b0;
  logic [7:0] cmdCode = 8'h00, dataWrByte = 8'h00;
  logic vbusSense = 1'b1, busActivity = 1'b1;
  logic [7:0] dataRdByte;
  logic connectN, remoteWakeup, devStatIrq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_devstat_ctrl #(.CYCLES_PER_MS(CPM)) dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic doCmd(logic [7:0] c);
    cmdCode = c; cmdValid = 1'b1;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic doWr(logic [7:0] d);
    dataWrByte = d; dataWrValid = 1'b1;
    @(negedge clk); dataWrValid = 1'b0;
  endtask

  task automatic doRd(output logic [7:0] d);
    dataRdReq = 1'b1;
    @(negedge clk); dataRdReq = 1'b0;
    d = dataRdByte;
  endtask

  task automatic readStatus(string req, logic [7:0] exp);
    logic [7:0] v;
    doCmd(8'hFE); doRd(v); check(req, v, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // op: 0 command, 1 write, 2 read-and-compare; {op, byte, expected}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'hFD, 8'h00}, {2'd2, 8'h00, 8'h0F}, {2'd2, 8'h00, 8'hA5},
    {2'd2, 8'h00, 8'h0F}, {2'd0, 8'hFD, 8'h00}, {2'd2, 8'h00, 8'h0F},
    {2'd0, 8'hFE, 8'h00}, {2'd2, 8'h00, 8'h00}, {2'd1, 8'hFB, 8'h00},
    {2'd2, 8'h00, 8'h01}, {2'd0, 8'h55, 8'h00}, {2'd1, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00}, {2'd0, 8'hFE, 8'h00}
  };
  localparam string VREQ [NV] = '{"R10", "R10", "R10", "R10", "R10", "R10",
    "R9", "R9", "R9", "R9", "R11", "R11", "R11", "R11"};

  initial begin
    logic [7:0] v;
    @(negedge clk);
    // R12 reset state
    check("R12", {5'b0, connectN, remoteWakeup, devStatIrq}, 8'h04);
    rstN = 1'b1;
    @(negedge clk);
    readStatus("R12", 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: doCmd(VEC[i][15:8]);
        2'd1: doWr(VEC[i][15:8]);
        default: begin doRd(v); check(VREQ[i], v, VEC[i][7:0]); end
      endcase
    end
    // R11 write after unknown command did not disconnect; R1 pin low
    check("R1", {7'b0, connectN}, 8'h00);
    readStatus("R11", 8'h01);

    // R2 low run of exactly WIN edges is ignored
    vbusSense = 1'b0; idle(WIN); vbusSense = 1'b1; idle(1);
    check("R2", {7'b0, connectN}, 8'h00);
    // R2/R3 long low run drops connection
    vbusSense = 1'b0; idle(WIN + 4);
    check("R2", {7'b0, connectN}, 8'h01);
    check("R8", {7'b0, devStatIrq}, 8'h01);
    vbusSense = 1'b1; idle(1);
    readStatus("R3", 8'h02);
    readStatus("R3", 8'h00);
    check("R8", {7'b0, devStatIrq}, 8'h00);
    // R6 write 0 to suspend while disconnected: no pulse
    doCmd(8'hFE); doWr(8'h00);
    check("R6", {7'b0, remoteWakeup}, 8'h00);

    // reconnect, R4 short idle ignored
    doWr(8'h01);
    check("R1", {7'b0, connectN}, 8'h00);
    busActivity = 1'b0; idle(WIN); busActivity = 1'b1; idle(1);
    readStatus("R4", 8'h01);
    busActivity = 1'b0; idle(WIN + 3);
    check("R8", {7'b0, devStatIrq}, 8'h01);
    readStatus("R7", 8'h0D);
    readStatus("R4", 8'h05);
    // R6 write with suspend bit 1: no wake
    doCmd(8'hFE); doWr(8'h05);
    check("R6", {7'b0, remoteWakeup}, 8'h00);
    // R6 wake pulse
    doWr(8'h01);
    check("R6", {7'b0, remoteWakeup}, 8'h01);
    idle(1);
    check("R6", {7'b0, remoteWakeup}, 8'h00);
    readStatus("R6", 8'h05);
    // R5 activity resumes
    busActivity = 1'b1; idle(1);
    readStatus("R5", 8'h09);
    readStatus("R7", 8'h01);
    // R6 write 0 while not suspended: no pulse
    doCmd(8'hFE); doWr(8'h01);
    check("R6", {7'b0, remoteWakeup}, 8'h00);
    // R7 disconnect while suspended
    busActivity = 1'b0; idle(WIN + 3);
    readStatus("R7", 8'h0D);
    doCmd(8'hFE); doWr(8'h04);
    check("R6", {7'b0, remoteWakeup}, 8'h00);
    readStatus("R5", 8'h08);
    // R4 never suspends while disconnected
    idle(WIN + 5);
    readStatus("R4", 8'h00);
    busActivity = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule